// File: doc/BRIEF.md
# Power Domain Handshake Controller

This block switches a single selected power domain on or off by driving request bits and waiting on status bits. The request bits are shared among four requester words. Three of them are inputs: a firmware word, plus two auxiliary words for other requesters. The fourth is the local driver word, which this block owns and is the only one it may modify directly. For the firmware word, the block gives its owner a one-cycle clear mask. The two auxiliary words are never touched. The power hardware sits outside and answers on a status word and a fuse-distribution word.

Only one command is accepted at a time. A command gives a direction (on or off) and a domain code. Before acting, the controller lets the domain settle into its present state. Switching on can include a further wait on a fuse-distribution flag for the two main power wells. Each wait is bounded by a cycle limit supplied on an input. When the limit runs out, the controller raises an error flag and returns to idle with a done pulse.

Top module: `pd_handshake_ctrl`

## Requirements
- R1: Domain codes on `cmd_dom` are 0 misc IO, 1 well 1, 2 well 2, and 3 to 6 for interface domains A/E, B, C and D. Their request bits are 1, 29, 31, 3, 5, 7 and 9. Each status bit sits one position below its request bit. Code 7 is ignored: busy stays low, no done pulse occurs and the driver word does not change.
- R2: On an off command where any of the four words holds the domain's request bit, nothing is cleared until the status bit reads set.
- R3: On an off command the driver word's request bit is cleared if it was set. `fw_clear` carries the request bit for one cycle only if the firmware word held it. No other bit changes.
- R4: On an on command where no word holds the request bit, the driver bit is set only after the status bit reads clear.
- R5: On an on command where the driver word lacks the request bit, the bit is set, and then the controller waits for the status bit to read set.
- R6: For well 1 and well 2 only, once the status bit is set the controller also waits for the fuse flag. That flag is bit 26 for well 1 and bit 25 for well 2.
- R7: A wait whose condition is not met for `tmo_limit`+1 sampled cycles ends the command. The controller raises `err`, pulses `done` and goes idle, leaving any pending clear undone. `err` holds until the next accepted command.
- R8: Commands are accepted only while idle. `busy` is high while a command is in progress, and a `cmd_valid` seen then is ignored. `done` is high for exactly one cycle, with `busy` low in that cycle.
- R9: An on command for a domain whose driver bit is already set finishes with `done` in the cycle right after acceptance.
- R10: During reset, `busy`, `done`, `err`, `drv_word` and `fw_clear` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_on | input | 1 | 1 = switch on, 0 = switch off |
| cmd_dom | input | 3 | Domain code |
| tmo_limit | input | TMO_W | Wait limit in cycles |
| fw_word | input | 32 | Firmware requester word |
| aux0_word | input | 32 | First auxiliary requester word |
| aux1_word | input | 32 | Second auxiliary requester word |
| status_word | input | 32 | Power status bits from the hardware |
| fuse_word | input | 32 | Fuse-distribution flags from the hardware |
| drv_word | output | 32 | Local driver requester word |
| fw_clear | output | 32 | One-cycle mask of bits the firmware word owner must clear |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Last command ended on a timeout |

## Verification
From the ports, the hardest situations to reach are those where status disagrees with the requests: a status bit still set when nobody requests the domain, a status bit that never comes, and a fuse flag that stays low while the status is already set. The bench responder derives status and fuse from the OR of all four words through a short delay. It also has per-bit stick and kill masks. The stick mask holds a status bit high to expose the pre-wait of an on command. The kill mask holds a status or fuse bit low, which forces each timeout path and shows that a pending clear is left undone.

// File: rtl/pd_pkg.sv
package pd_pkg;

  localparam int PD_WORD_W = 32;
  localparam int PD_DOM_W  = 3;

  typedef enum logic [PD_DOM_W-1:0] {
    DOM_MISC = 3'd0,
    DOM_WELL1 = 3'd1,
    DOM_WELL2 = 3'd2,
    DOM_IF_AE = 3'd3,
    DOM_IF_B = 3'd4,
    DOM_IF_C = 3'd5,
    DOM_IF_D = 3'd6,
    DOM_NONE = 3'd7
  } pd_dom_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SET,
    ST_CLEAR,
    ST_W_CLR,
    ST_SET_REQ,
    ST_W_ON,
    ST_W_FUSE,
    ST_FINISH
  } pd_st_e;

  // position of the request bit for a domain code
  function automatic int unsigned pd_req_pos(logic [PD_DOM_W-1:0] d);
    case (pd_dom_e'(d))
      DOM_MISC:  return 1;
      DOM_WELL1: return 29;
      DOM_WELL2: return 31;
      DOM_IF_AE: return 3;
      DOM_IF_B:  return 5;
      DOM_IF_C:  return 7;
      DOM_IF_D:  return 9;
      default:   return 0;
    endcase
  endfunction

  // status sits directly below its request bit
  function automatic int unsigned pd_sta_pos(logic [PD_DOM_W-1:0] d);
    return pd_req_pos(d) - 1;
  endfunction

  function automatic logic pd_dom_valid(logic [PD_DOM_W-1:0] d);
    return pd_dom_e'(d) != DOM_NONE;
  endfunction

  function automatic logic pd_is_well(logic [PD_DOM_W-1:0] d);
    return (pd_dom_e'(d) == DOM_WELL1) || (pd_dom_e'(d) == DOM_WELL2);
  endfunction

  function automatic int unsigned pd_fuse_pos(logic [PD_DOM_W-1:0] d);
    return (pd_dom_e'(d) == DOM_WELL1) ? 26 : 25;
  endfunction

endpackage

// File: rtl/pd_dom_decode.sv
module pd_dom_decode
  import pd_pkg::*;
#(
  parameter int WORD_W = PD_WORD_W,
  parameter int DOM_W  = PD_DOM_W
) (
  input  logic [DOM_W-1:0]  dom,
  output logic              dom_ok,
  output logic              dom_well,
  output logic [WORD_W-1:0] req_mask,
  output logic [WORD_W-1:0] sta_mask,
  output logic [WORD_W-1:0] fuse_mask
);

  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  always_comb begin
    dom_ok    = pd_dom_valid(dom);
    dom_well  = pd_is_well(dom);
    req_mask  = dom_ok ? (ONE << pd_req_pos(dom)) : '0;
    sta_mask  = dom_ok ? (ONE << pd_sta_pos(dom)) : '0;
    fuse_mask = dom_well ? (ONE << pd_fuse_pos(dom)) : '0;
  end

endmodule

// File: rtl/pd_wait_timer.sv
module pd_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [TMO_W-1:0] lim,
  output logic             hit
);

  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (cnt != lim) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == lim);

  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)) else $error("timer not restarted"); // R7

endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_pkg::*;
#(
  parameter int WORD_W = PD_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_on,
  input  logic              dom_ok,
  input  logic              dom_well,
  input  logic [WORD_W-1:0] dec_req,
  input  logic [WORD_W-1:0] dec_sta,
  input  logic [WORD_W-1:0] dec_fuse,
  input  logic [WORD_W-1:0] fw_word,
  input  logic [WORD_W-1:0] aux0_word,
  input  logic [WORD_W-1:0] aux1_word,
  input  logic [WORD_W-1:0] status_word,
  input  logic [WORD_W-1:0] fuse_word,
  input  logic              tmr_hit,
  output logic              tmr_clr,
  output logic [WORD_W-1:0] drv_word,
  output logic [WORD_W-1:0] fw_clear,
  output logic              busy,
  output logic              done,
  output logic              err
);

  pd_st_e st, st_nx;
  logic              cur_on, snap_any, snap_fw, snap_drv, well;
  logic [WORD_W-1:0] req_m, sta_m, fuse_m, drv_q;
  logic              err_q;

  // named events
  logic accept, any_now, fw_now, drv_now;
  logic sta_set, fuse_set, in_wait, cond_met, tmo_evt, set_evt, clr_evt;

  always_comb begin
    accept   = (st == ST_IDLE) && cmd_valid && dom_ok;
    any_now  = |((fw_word | drv_q | aux0_word | aux1_word) & dec_req);
    fw_now   = |(fw_word & dec_req);
    drv_now  = |(drv_q & dec_req);
    sta_set  = |(status_word & sta_m);
    fuse_set = |(fuse_word & fuse_m);
    in_wait  = (st == ST_W_SET) || (st == ST_W_CLR) ||
               (st == ST_W_ON) || (st == ST_W_FUSE);
    case (st)
      ST_W_SET:  cond_met = sta_set;
      ST_W_CLR:  cond_met = !sta_set;
      ST_W_ON:   cond_met = sta_set;
      ST_W_FUSE: cond_met = fuse_set;
      default:   cond_met = 1'b0;
    endcase
    tmo_evt = in_wait && !cond_met && tmr_hit;
    set_evt = (st == ST_SET_REQ);
    clr_evt = (st == ST_CLEAR) && snap_drv;
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: begin
        if (accept) begin
          if (cmd_on) begin
            if (!any_now)      st_nx = ST_W_CLR;
            else if (!drv_now) st_nx = ST_SET_REQ;
            else               st_nx = ST_FINISH;
          end else begin
            st_nx = any_now ? ST_W_SET : ST_CLEAR;
          end
        end
      end
      ST_W_SET:   if (cond_met) st_nx = ST_CLEAR;   else if (tmo_evt) st_nx = ST_FINISH;
      ST_CLEAR:   st_nx = ST_FINISH;
      ST_W_CLR:   if (cond_met) st_nx = ST_SET_REQ; else if (tmo_evt) st_nx = ST_FINISH;
      ST_SET_REQ: st_nx = ST_W_ON;
      ST_W_ON: begin
        if (cond_met)     st_nx = well ? ST_W_FUSE : ST_FINISH;
        else if (tmo_evt) st_nx = ST_FINISH;
      end
      ST_W_FUSE:  if (cond_met || tmo_evt) st_nx = ST_FINISH;
      ST_FINISH:  st_nx = ST_IDLE;
      default:    st_nx = ST_IDLE;
    endcase
  end

  assign tmr_clr = !in_wait || (st_nx != st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_on   <= 1'b0;
      snap_any <= 1'b0;
      snap_fw  <= 1'b0;
      snap_drv <= 1'b0;
      well     <= 1'b0;
      req_m    <= '0;
      sta_m    <= '0;
      fuse_m   <= '0;
      drv_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      st <= st_nx;
      if (accept) begin
        cur_on   <= cmd_on;
        snap_any <= any_now;
        snap_fw  <= fw_now;
        snap_drv <= drv_now;
        well     <= dom_well;
        req_m    <= dec_req;
        sta_m    <= dec_sta;
        fuse_m   <= dec_fuse;
        err_q    <= 1'b0;
      end
      if (tmo_evt) err_q <= 1'b1;
      if (set_evt)      drv_q <= drv_q | req_m;
      else if (clr_evt) drv_q <= drv_q & ~req_m;
    end
  end

  assign drv_word = drv_q;
  assign fw_clear = ((st == ST_CLEAR) && snap_fw) ? req_m : '0;
  assign busy     = (st != ST_IDLE) && (st != ST_FINISH);
  assign done     = (st == ST_FINISH);
  assign err      = err_q;

  AST_DRV_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_evt || clr_evt) |=> $stable(drv_word)) else $error("drv word moved"); // R3
  AST_CLR_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLEAR && snap_any) |-> (($past(status_word) & sta_m) != '0))
    else $error("clear before status"); // R2
  AST_SET_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |-> cur_on) else $error("set on off command"); // R5
  AST_FW_CLR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_clear != '0) |-> (!cur_on && $countones(fw_clear) == 1))
    else $error("bad firmware clear"); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done too long"); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("busy with done"); // R8
  AST_FUSE_WELL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_W_FUSE) |-> (well && cur_on)) else $error("fuse wait on non-well"); // R6
  AST_ERR_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (err && done)) else $error("timeout not flagged"); // R7

endmodule

// File: rtl/pd_handshake_ctrl.sv
module pd_handshake_ctrl
  import pd_pkg::*;
#(
  parameter int WORD_W = PD_WORD_W,
  parameter int DOM_W  = PD_DOM_W,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_on,
  input  logic [DOM_W-1:0]  cmd_dom,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic [WORD_W-1:0] fw_word,
  input  logic [WORD_W-1:0] aux0_word,
  input  logic [WORD_W-1:0] aux1_word,
  input  logic [WORD_W-1:0] status_word,
  input  logic [WORD_W-1:0] fuse_word,
  output logic [WORD_W-1:0] drv_word,
  output logic [WORD_W-1:0] fw_clear,
  output logic              busy,
  output logic              done,
  output logic              err
);

  logic              dom_ok, dom_well, tmr_clr, tmr_hit;
  logic [WORD_W-1:0] dec_req, dec_sta, dec_fuse;

  pd_dom_decode #(.WORD_W(WORD_W), .DOM_W(DOM_W)) u_dec (
    .dom       (cmd_dom),
    .dom_ok    (dom_ok),
    .dom_well  (dom_well),
    .req_mask  (dec_req),
    .sta_mask  (dec_sta),
    .fuse_mask (dec_fuse)
  );

  pd_wait_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .lim   (tmo_limit),
    .hit   (tmr_hit)
  );

  pd_seq #(.WORD_W(WORD_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_on      (cmd_on),
    .dom_ok      (dom_ok),
    .dom_well    (dom_well),
    .dec_req     (dec_req),
    .dec_sta     (dec_sta),
    .dec_fuse    (dec_fuse),
    .fw_word     (fw_word),
    .aux0_word   (aux0_word),
    .aux1_word   (aux1_word),
    .status_word (status_word),
    .fuse_word   (fuse_word),
    .tmr_hit     (tmr_hit),
    .tmr_clr     (tmr_clr),
    .drv_word    (drv_word),
    .fw_clear    (fw_clear),
    .busy        (busy),
    .done        (done),
    .err         (err)
  );

  AST_IGNORE_BAD_DOM: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && cmd_valid && !dom_ok) |=> (!busy && !done))
    else $error("invalid domain accepted"); // R1

endmodule

// File: tb/tb_pd_handshake_ctrl.sv
module tb_pd_handshake_ctrl;

  localparam int W  = 32;
  localparam int TW = 16;
  localparam logic [W-1:0] STA_ALL = 32'h5000_0155;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, cmd_valid, cmd_on;
  logic [2:0]    cmd_dom;
  logic [TW-1:0] tmo_limit;
  logic [W-1:0]  fw_word, aux0_word, aux1_word, status_word, fuse_word;
  logic [W-1:0]  drv_word, fw_clear;
  logic          busy, done, err;

  // power hardware responder
  logic [W-1:0] req_p1, req_p2, fuse_p, stick, kill, fkill, fw_load_val;
  logic         fw_load;

  always @(posedge clk) begin
    if (!rst_n) begin
      req_p1 <= '0; req_p2 <= '0; fuse_p <= '0; fw_word <= '0;
    end else begin
      req_p1 <= fw_word | drv_word | aux0_word | aux1_word;
      req_p2 <= req_p1;
      fuse_p <= status_word;
      if (fw_load) fw_word <= fw_load_val;
      else         fw_word <= fw_word & ~fw_clear;
    end
  end
  assign status_word = (((req_p2 >> 1) & STA_ALL) | stick) & ~kill;
  assign fuse_word   = {5'b0, fuse_p[28], fuse_p[30], 25'b0} & ~fkill;

  pd_handshake_ctrl #(.TMO_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_on(cmd_on),
    .cmd_dom(cmd_dom), .tmo_limit(tmo_limit), .fw_word(fw_word),
    .aux0_word(aux0_word), .aux1_word(aux1_word), .status_word(status_word),
    .fuse_word(fuse_word), .drv_word(drv_word), .fw_clear(fw_clear),
    .busy(busy), .done(done), .err(err)
  );

  int total = 0;
  int bad = 0;

  // request bit per domain code, R1
  function automatic int rbit(logic [2:0] d);
    int t [7] = '{1, 29, 31, 3, 5, 7, 9};
    return t[d];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_fw(logic [2:0] d, logic v);
    @(negedge clk);
    fw_load = 1'b1;
    fw_load_val = v ? (fw_word | (32'd1 << rbit(d))) : (fw_word & ~(32'd1 << rbit(d)));
    @(negedge clk);
    fw_load = 1'b0;
  endtask

  task automatic issue(logic on, logic [2:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_on = on; cmd_dom = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 3000) begin
      @(negedge clk);
      k++;
    end
    if (!done) chk("R8 done never seen", 32'd0, 32'd1);
  endtask

  typedef struct packed {
    logic       on;
    logic [2:0] dom;
    logic       fw_pre;
    logic       aux_pre;
    logic       exp_drv;
    logic       exp_fw;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 3'd4, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 3'd6, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b0, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    logic [W-1:0] snap;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_on = 1'b0; cmd_dom = '0;
    tmo_limit = 16'd40; aux0_word = '0; aux1_word = '0;
    stick = '0; kill = '0; fkill = '0; fw_load = 1'b0; fw_load_val = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", {31'd0, busy}, 32'd0);
    chk("R10 done", {31'd0, done}, 32'd0);
    chk("R10 err", {31'd0, err}, 32'd0);
    chk("R10 drv_word", drv_word, 32'd0);
    chk("R10 fw_clear", fw_clear, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      set_fw(VEC[i].dom, VEC[i].fw_pre);
      if (VEC[i].aux_pre) aux0_word = aux0_word | (32'd1 << rbit(VEC[i].dom));
      else                aux0_word = aux0_word & ~(32'd1 << rbit(VEC[i].dom));
      issue(VEC[i].on, VEC[i].dom);
      wait_done(k);
      chk($sformatf("R5 R3 vec%0d err", i), {31'd0, err}, 32'd0);
      chk($sformatf("R5 R3 vec%0d drv bit", i), {31'd0, drv_word[rbit(VEC[i].dom)]},
          {31'd0, VEC[i].exp_drv});
      chk($sformatf("R3 vec%0d fw bit", i), {31'd0, fw_word[rbit(VEC[i].dom)]},
          {31'd0, VEC[i].exp_fw});
      if (VEC[i].aux_pre)
        chk($sformatf("R3 vec%0d aux kept", i), {31'd0, aux0_word[rbit(VEC[i].dom)]}, 32'd1);
      if (i == 1) chk("R9 already-on latency", k, 32'd0);
      @(negedge clk);
      chk("R8 done single cycle", {31'd0, done}, 32'd0);
      repeat (8) @(negedge clk);
    end

    // R7 R2 timeout while request present and status withheld
    issue(1'b1, 3'd5);
    wait_done(k);
    repeat (8) @(negedge clk);
    kill = 32'd1 << 6;
    repeat (4) @(negedge clk);
    tmo_limit = 16'd20;
    issue(1'b0, 3'd5);
    wait_done(k);
    chk("R7 timeout length", k, 32'd21);
    chk("R7 err raised", {31'd0, err}, 32'd1);
    chk("R2 drv kept on timeout", {31'd0, drv_word[7]}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R7 err held", {31'd0, err}, 32'd1);
    kill = '0;
    tmo_limit = 16'd40;
    repeat (6) @(negedge clk);
    issue(1'b0, 3'd5);
    wait_done(k);
    chk("R7 err cleared by new command", {31'd0, err}, 32'd0);
    chk("R3 drv cleared after retry", {31'd0, drv_word[7]}, 32'd0);
    repeat (8) @(negedge clk);

    // R4 stale status with no requester
    stick = 32'd1 << 8;
    repeat (4) @(negedge clk);
    issue(1'b1, 3'd6);
    repeat (10) @(negedge clk);
    chk("R4 still waiting", {31'd0, busy}, 32'd1);
    chk("R4 drv not set before clear", {31'd0, drv_word[9]}, 32'd0);
    stick = '0;
    wait_done(k);
    chk("R4 err", {31'd0, err}, 32'd0);
    chk("R4 drv set after clear", {31'd0, drv_word[9]}, 32'd1);
    repeat (8) @(negedge clk);

    // R6 fuse flag withheld for well 1
    fkill = 32'd1 << 26;
    issue(1'b1, 3'd1);
    wait_done(k);
    chk("R6 fuse timeout err", {31'd0, err}, 32'd1);
    chk("R6 drv set before fuse wait", {31'd0, drv_word[29]}, 32'd1);
    chk("R6 status seen", {31'd0, status_word[28]}, 32'd1);
    fkill = '0;
    repeat (4) @(negedge clk);
    issue(1'b0, 3'd1);
    wait_done(k);
    chk("R6 off after fuse test", {31'd0, drv_word[29]}, 32'd0);
    repeat (8) @(negedge clk);

    // R8 command while busy is ignored
    kill = 32'd1 << 0;
    issue(1'b1, 3'd0);
    chk("R8 busy during wait", {31'd0, busy}, 32'd1);
    cmd_valid = 1'b1; cmd_on = 1'b1; cmd_dom = 3'd4;
    @(negedge clk);
    cmd_valid = 1'b0;
    kill = '0;
    wait_done(k);
    chk("R8 first command done", {31'd0, drv_word[1]}, 32'd1);
    repeat (10) @(negedge clk);
    chk("R8 busy command dropped", {31'd0, drv_word[5]}, 32'd0);
    chk("R8 idle after", {31'd0, busy}, 32'd0);

    // R1 invalid domain code
    snap = drv_word;
    issue(1'b1, 3'd7);
    chk("R1 code 7 not busy", {31'd0, busy}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R1 code 7 no done", {31'd0, done}, 32'd0);
    chk("R1 code 7 drv unchanged", drv_word, snap);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule